// File: doc/BRIEF.md
# RTC Alarm Interrupt and Clock-Out Controller

This block drives the one active-low output pin of a real-time clock. The pin carries either an alarm interrupt or a clock derived from the 32.768 kHz oscillator. The block compares two alarm register sets with the current calendar fields. Each alarm has its own field-enable mask. The block also keeps one sticky status flag per alarm.

An internal prescaler divides the oscillator clock by `DIV_1HZ` and produces a one-cycle 1 Hz tick. Alarm comparison happens only on that tick. A match counts once, on the first tick at which the enabled fields are equal. The prescaler also produces the divide-by-8 clock and the 1 Hz square wave that the output selector can route to the pin.

In latched mode a match holds the pin low until software clears the status. In pulsed mode every match gives a low pulse of a quarter second. Whenever the output selector picks a clock, that clock replaces the interrupt function on the pin. The time counters, the serial bus and storage live elsewhere in the chip.

Top module: `rtc_alarm_out`

## Requirements
- R1: While `rst_n` is low at a clock edge, both status flags clear and the prescaler returns to zero. With `fo_sel_i` = 00 and no flag set, the pin is high.
- R2: `fo_sel_i` chooses what drives the pin:
  - 01 passes the oscillator clock to the pin.
  - 10 drives the pin high while prescaler count mod 8 is 4 to 7, and low otherwise (clock divided by 8).
  - 11 drives the pin high while the prescaler count is at least `DIV_1HZ/2`, and low otherwise.
- R3: When `fo_sel_i` is not 00, no alarm state affects the pin. Status flags still get set on matches.
- R4: Time words are packed as sec[5:0], min[11:6], hour[16:12], day-of-week[19:17], date[24:20], month[28:25]. Mask bit 0 to 5 enables sec, min, hour, day-of-week, date and month in that order. A field whose mask bit is clear is ignored. An all-zero mask never matches.
- R5: Matching is evaluated only on the tick. A hit happens when the alarm matches on this tick and did not match on the previous tick. Equality that persists over later ticks causes no new hit.
- R6: A hit sets the status flag of that alarm, visible after the tick edge. The flag stays set until a cycle with `clr_i` high and no hit on that alarm, because a hit in the same cycle as a clear wins. With `fo_sel_i` = 00 and `im_i` = 0, the pin is low while any flag is set whose alarm enable is 1.
- R7: An alarm whose enable (`al0e_i` or `al1e_i`) is 0 still sets its flag but never pulls the pin low.
- R8: With `im_i` = 1 and `fo_sel_i` = 00, each hit of an enabled alarm pulls the pin low for exactly `DIV_1HZ/4` cycles, starting after the tick edge. Every later hit fires again.
- R9: Either alarm can drive the pin on its own. Each alarm has its own pulse timer, and the pin is low while either timer runs.
- R10: The first tick after reset release falls on the `DIV_1HZ`-th clock edge. Later ticks follow every `DIV_1HZ` edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32.768 kHz oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cur_time_i | input | 29 | Current calendar fields, packed as in R4 |
| alm0_time_i | input | 29 | Alarm 0 compare values |
| alm0_mask_i | input | 6 | Alarm 0 field enables |
| alm1_time_i | input | 29 | Alarm 1 compare values |
| alm1_mask_i | input | 6 | Alarm 1 field enables |
| al0e_i | input | 1 | Alarm 0 interrupt enable |
| al1e_i | input | 1 | Alarm 1 interrupt enable |
| im_i | input | 1 | 1 = pulsed interrupt mode, 0 = latched |
| fo_sel_i | input | 2 | Output select: 00 alarm, 01 full clock, 10 divide-by-8, 11 1 Hz |
| clr_i | input | 1 | Status clear strobe for both flags |
| irq_fout_n_o | output | 1 | Shared active-low interrupt / clock output |
| alm_flag_o | output | 2 | Alarm status flags, bit 0 for alarm 0 |

## Verification
The assertions assume that every input is stable across the rising clock edge. The stimulus therefore changes calendar fields, masks, enables, the output select and the clear strobe only at the falling edge. The assertions also take `DIV_1HZ` to be a multiple of 8 and at least 16, so that ticks never fall on consecutive cycles and the 1 Hz wave is low just after a tick. The bench uses a short prescaler that keeps both assumptions. It moves the calendar fields only just after a tick, except in the one case that lines a clear up with a hit on purpose.

// File: rtl/rtc_alarm_pkg.sv
// Shared types for the RTC alarm / clock-out controller.
// Assumes: calendar fields are binary and already range-limited upstream.
package rtc_alarm_pkg;

    localparam int FIELD_N = 6;
    localparam int TIME_W  = 29;
    localparam int ALM_N   = 2;

    // Packed calendar word, seconds in the least significant bits.
    typedef struct packed {
        logic [3:0] mon;
        logic [4:0] date;
        logic [2:0] dow;
        logic [4:0] hour;
        logic [5:0] min;
        logic [5:0] sec;
    } rtc_time_t;

    // Pin source select.
    typedef enum logic [1:0] {
        FO_ALARM = 2'b00,
        FO_FULL  = 2'b01,
        FO_DIV8  = 2'b10,
        FO_1HZ   = 2'b11
    } fo_sel_e;

endpackage

// File: rtl/rtc_clk_div.sv
// Prescaler: divides the oscillator clock into a one-cycle 1 Hz tick,
// a divide-by-8 square wave and a 50 % duty 1 Hz square wave.
// Assumes: DIV_1HZ is a multiple of 8 and at least 16.
module rtc_clk_div #(
    parameter int DIV_1HZ = 32768
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o,
    output logic div8_o,
    output logic hz1_o
);
    localparam int CNT_W = $clog2(DIV_1HZ);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV_1HZ - 1);
    localparam logic [CNT_W-1:0] HALF = CNT_W'(DIV_1HZ / 2);

    logic [CNT_W-1:0] cnt_q;

    // Free-running count that wraps after DIV_1HZ cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                  cnt_q <= cnt_q + 1'b1;
    end

    assign tick_o = (cnt_q == LAST);
    assign div8_o = cnt_q[2];
    assign hz1_o  = (cnt_q >= HALF);

    // R10
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);

    // R2
    div8_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o) |=> (!div8_o && !hz1_o));

endmodule

// File: rtl/rtc_alarm_match.sv
// One alarm comparator: masks the calendar fields, compares them on the
// 1 Hz tick and reports a hit only on the first matching tick.
// Assumes: cur_i and alm_i are stable across the tick edge.
module rtc_alarm_match
    import rtc_alarm_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_i,
    input  rtc_time_t          cur_i,
    input  rtc_time_t          alm_i,
    input  logic [FIELD_N-1:0] mask_i,
    output logic               hit_o
);
    logic [FIELD_N-1:0] eq;
    logic               match;
    logic               prev_q;

    // Per-field equality, bit order follows the mask.
    always_comb begin
        eq[0] = (cur_i.sec  == alm_i.sec);
        eq[1] = (cur_i.min  == alm_i.min);
        eq[2] = (cur_i.hour == alm_i.hour);
        eq[3] = (cur_i.dow  == alm_i.dow);
        eq[4] = (cur_i.date == alm_i.date);
        eq[5] = (cur_i.mon  == alm_i.mon);
    end

    assign match = (&(eq | ~mask_i)) && (|mask_i);

    // Remember the compare result of the last tick.
    always_ff @(posedge clk) begin
        if (!rst_n)      prev_q <= 1'b0;
        else if (tick_i) prev_q <= match;
    end

    assign hit_o = tick_i && match && !prev_q;

    // R4
    no_mask_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_i == '0) |-> !hit_o);

    // R5
    hit_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> tick_i);

endmodule

// File: rtl/rtc_irq_ctrl.sv
// Interrupt state: sticky status flags, per-alarm pulse timers and the
// resulting request to pull the pin low.
// Assumes: hit_i bits are single-cycle strobes from the comparators.
module rtc_irq_ctrl
    import rtc_alarm_pkg::*;
#(
    parameter int PULSE_CYC = 8192
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ALM_N-1:0] hit_i,
    input  logic [ALM_N-1:0] alm_en_i,
    input  logic             im_i,
    input  logic [1:0]       fo_sel_i,
    input  logic             clr_i,
    output logic [ALM_N-1:0] flag_o,
    output logic             alarm_low_o
);
    localparam int TMR_W = $clog2(PULSE_CYC + 1);
    localparam logic [TMR_W-1:0] TMR_LOAD = TMR_W'(PULSE_CYC);

    logic [ALM_N-1:0] flag_q;
    logic [ALM_N-1:0] pulse_on;
    logic             alarm_path;

    assign alarm_path = (fo_sel_i == FO_ALARM);

    for (genvar i = 0; i < ALM_N; i++) begin : g_alm
        logic [TMR_W-1:0] tmr_q;
        logic             start;

        assign start = hit_i[i] && alm_en_i[i] && im_i && alarm_path;

        // Sticky status: a hit outranks a clear in the same cycle.
        always_ff @(posedge clk) begin
            if (!rst_n)        flag_q[i] <= 1'b0;
            else if (hit_i[i]) flag_q[i] <= 1'b1;
            else if (clr_i)    flag_q[i] <= 1'b0;
        end

        // Pulse timer: loads on a pulsed-mode hit, then counts down to zero.
        always_ff @(posedge clk) begin
            if (!rst_n)              tmr_q <= '0;
            else if (start)          tmr_q <= TMR_LOAD;
            else if (tmr_q != '0)    tmr_q <= tmr_q - 1'b1;
        end

        assign pulse_on[i] = (tmr_q != '0);

        // R6
        flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_q[i] && !clr_i) |=> flag_q[i]);

        // R6
        flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i && !hit_i[i]) |=> !flag_q[i]);

        // R8
        pulse_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (hit_i[i] && alm_en_i[i] && im_i && fo_sel_i == FO_ALARM) |=> pulse_on[i]);
    end

    // Combine latched or pulsed requests, only on the alarm path.
    always_comb begin
        if (!alarm_path)  alarm_low_o = 1'b0;
        else if (im_i)    alarm_low_o = |pulse_on;
        else              alarm_low_o = |(flag_q & alm_en_i);
    end

    assign flag_o = flag_q;

    // R7
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alm_en_i == '0) |-> !alarm_low_o);

endmodule

// File: rtl/rtc_alarm_out.sv
// Top: two alarm comparators, prescaler, interrupt state and the pin mux
// that shares one active-low output between alarms and clock outputs.
// Assumes: all inputs are synchronous to clk; DIV_1HZ multiple of 8, >= 16.
module rtc_alarm_out
    import rtc_alarm_pkg::*;
#(
    parameter int DIV_1HZ = 32768
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [TIME_W-1:0]  cur_time_i,
    input  logic [TIME_W-1:0]  alm0_time_i,
    input  logic [FIELD_N-1:0] alm0_mask_i,
    input  logic [TIME_W-1:0]  alm1_time_i,
    input  logic [FIELD_N-1:0] alm1_mask_i,
    input  logic               al0e_i,
    input  logic               al1e_i,
    input  logic               im_i,
    input  logic [1:0]         fo_sel_i,
    input  logic               clr_i,
    output logic               irq_fout_n_o,
    output logic [ALM_N-1:0]   alm_flag_o
);
    localparam int PULSE_CYC = DIV_1HZ / 4;

    logic tick, div8, hz1, alarm_low;
    logic [ALM_N-1:0]              hit;
    logic [ALM_N-1:0][TIME_W-1:0]  alm_vec;
    logic [ALM_N-1:0][FIELD_N-1:0] mask_vec;

    assign alm_vec  = {alm1_time_i, alm0_time_i};
    assign mask_vec = {alm1_mask_i, alm0_mask_i};

    rtc_clk_div #(.DIV_1HZ(DIV_1HZ)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick),
        .div8_o (div8),
        .hz1_o  (hz1)
    );

    for (genvar i = 0; i < ALM_N; i++) begin : g_cmp
        rtc_alarm_match u_match (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick_i (tick),
            .cur_i  (rtc_time_t'(cur_time_i)),
            .alm_i  (rtc_time_t'(alm_vec[i])),
            .mask_i (mask_vec[i]),
            .hit_o  (hit[i])
        );
    end

    rtc_irq_ctrl #(.PULSE_CYC(PULSE_CYC)) u_irq (
        .clk         (clk),
        .rst_n       (rst_n),
        .hit_i       (hit),
        .alm_en_i    ({al1e_i, al0e_i}),
        .im_i        (im_i),
        .fo_sel_i    (fo_sel_i),
        .clr_i       (clr_i),
        .flag_o      (alm_flag_o),
        .alarm_low_o (alarm_low)
    );

    // Pin source select; alarm path is active-low.
    always_comb begin
        case (fo_sel_i)
            FO_FULL:  irq_fout_n_o = clk;
            FO_DIV8:  irq_fout_n_o = div8;
            FO_1HZ:   irq_fout_n_o = hz1;
            default:  irq_fout_n_o = !alarm_low;
        endcase
    end

    // R2
    hz1_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && fo_sel_i == FO_1HZ) |=> (fo_sel_i != FO_1HZ || !irq_fout_n_o));

    // R3
    clock_mode_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit[0] && fo_sel_i != FO_ALARM) |=> alm_flag_o[0]);

endmodule

// File: tb/sim_rtc_alarm_out.sv
module sim_rtc_alarm_out;
    localparam int CLK_P = 20;
    localparam int DIV   = 256;
    localparam int PULSE = DIV / 4;

    logic        clk = 0;
    logic        rst_n = 0;
    logic [28:0] cur = '0, a0 = '0, a1 = '0;
    logic [5:0]  m0 = '0, m1 = '0;
    logic        al0e = 0, al1e = 0, im = 0, clr = 0;
    logic [1:0]  fo = 2'b00;
    logic        pin;
    logic [1:0]  flags;

    int n_chk = 0, n_err = 0;
    bit done = 0;

    // reference model state
    int m_cnt = 0;
    bit m_prev [2];
    bit m_flag [2];
    int m_tmr  [2];

    always #(CLK_P/2) clk = ~clk;

    rtc_alarm_out #(.DIV_1HZ(DIV)) u0 (
        .clk(clk), .rst_n(rst_n), .cur_time_i(cur),
        .alm0_time_i(a0), .alm0_mask_i(m0),
        .alm1_time_i(a1), .alm1_mask_i(m1),
        .al0e_i(al0e), .al1e_i(al1e), .im_i(im), .fo_sel_i(fo), .clr_i(clr),
        .irq_fout_n_o(pin), .alm_flag_o(flags)
    );

    function automatic logic [28:0] mk(input int mon, date, dow, hour, mn, sec);
        return {4'(mon), 5'(date), 3'(dow), 5'(hour), 6'(mn), 6'(sec)};
    endfunction

    function automatic bit mdl_match(input logic [28:0] c, input logic [28:0] a, input logic [5:0] m);
        int lo [6];
        int w  [6];
        bit any = 0;
        bit ok  = 1;
        lo = '{0, 6, 12, 17, 20, 25};
        w  = '{6, 6, 5, 3, 5, 4};
        for (int f = 0; f < 6; f++) begin
            if (m[f]) begin
                any = 1;
                if (((int'(c) >> lo[f]) & ((1 << w[f]) - 1)) != ((int'(a) >> lo[f]) & ((1 << w[f]) - 1)))
                    ok = 0;
            end
        end
        return any && ok;
    endfunction

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
        end
    endtask

    // behavioural model, one step per rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0;
            for (int i = 0; i < 2; i++) begin m_prev[i] = 0; m_flag[i] = 0; m_tmr[i] = 0; end
        end else begin
            bit tk;
            tk = (m_cnt == DIV - 1);
            for (int i = 0; i < 2; i++) begin
                bit mt, hit, en;
                mt  = (i == 0) ? mdl_match(cur, a0, m0) : mdl_match(cur, a1, m1);
                en  = (i == 0) ? al0e : al1e;
                hit = tk && mt && !m_prev[i];
                if (tk) m_prev[i] = mt;
                if (hit) m_flag[i] = 1; else if (clr) m_flag[i] = 0;
                if (hit && en && im && fo == 2'b00) m_tmr[i] = PULSE;
                else if (m_tmr[i] > 0) m_tmr[i]--;
            end
            m_cnt = tk ? 0 : m_cnt + 1;
        end
    end

    function automatic bit exp_pin(input bit phase);
        case (fo)
            2'b01: return phase;
            2'b10: return (m_cnt % 8) >= 4;
            2'b11: return m_cnt >= DIV / 2;
            default: begin
                if (im) return !(m_tmr[0] > 0 || m_tmr[1] > 0);
                return !((m_flag[0] && al0e) || (m_flag[1] && al1e));
            end
        endcase
    endfunction

    task automatic cmp(input bit phase);
        bit e;
        string tag;
        e = exp_pin(phase);
        tag = (fo != 2'b00) ? "R2" : (im ? "R8" : "R6");
        chk(pin === e, tag, "pin", int'(pin), int'(e));
        chk(flags === {m_flag[1], m_flag[0]}, "R6", "flags", int'(flags), int'({m_flag[1], m_flag[0]}));
    endtask

    // compare on every clock, in both clock phases
    initial begin
        @(posedge rst_n);
        forever begin
            @(posedge clk); #(CLK_P/4); cmp(1);
            @(negedge clk); #(CLK_P/4); cmp(0);
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL R10 watchdog act=running exp=finished");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    task automatic after_tick();
        do @(negedge clk); while (m_cnt != 0);
    endtask

    task automatic pulse_clr();
        @(negedge clk); clr = 1;
        @(negedge clk); clr = 0;
        #1;
    endtask

    task automatic set_sec(input int s);
        cur = mk(3, 14, 2, 9, 30, s);
    endtask

    // one mismatching tick, then a matching tick
    task automatic arm_and_match(input int miss_sec, input int hit_sec);
        set_sec(miss_sec); after_tick();
        set_sec(hit_sec);  after_tick();
        #1;
    endtask

    task automatic measure_low(output int n);
        n = 0;
        #1;
        while (pin == 1'b0 && n < 4 * PULSE) begin
            n++;
            @(negedge clk); #1;
        end
    endtask

    initial begin
        int n;
        a0 = mk(3, 14, 2, 9, 30, 5);
        a1 = mk(3, 14, 2, 9, 45, 0);
        set_sec(5);
        m0 = 6'b000001; al0e = 1;
        repeat (4) @(negedge clk);
        #1;
        chk(pin === 1'b1, "R1", "pin in reset", int'(pin), 1);
        chk(flags === 2'b00, "R1", "flags in reset", int'(flags), 0);

        // R10: first tick on the DIV-th edge after release
        @(negedge clk); rst_n = 1;
        n = 0;
        do begin @(negedge clk); n++; end while (flags[0] !== 1'b1 && n < 2 * DIV);
        chk(n == DIV, "R10", "edges to first hit", n, DIV);
        #1;
        chk(pin === 1'b0, "R6", "latched pin low", int'(pin), 0);

        // R5: sustained equality does not re-fire
        pulse_clr();
        after_tick(); #1;
        chk(flags[0] === 1'b0, "R5", "no refire", int'(flags[0]), 0);
        chk(pin === 1'b1, "R6", "pin high after clear", int'(pin), 1);

        // R4: unmasked hour mismatch ignored
        a0 = mk(3, 14, 2, 11, 30, 5);
        m0 = 6'b100011;
        arm_and_match(6, 5);
        chk(flags[0] === 1'b1, "R4", "masked field ignored", int'(flags[0]), 1);
        pulse_clr();
        m0 = 6'b100111;
        arm_and_match(6, 5);
        chk(flags[0] === 1'b0, "R4", "enabled field blocks", int'(flags[0]), 0);
        m0 = 6'b000000; a0 = mk(3, 14, 2, 9, 30, 5);
        arm_and_match(6, 5);
        chk(flags[0] === 1'b0, "R4", "empty mask", int'(flags[0]), 0);
        chk(pin === 1'b1, "R4", "empty mask pin", int'(pin), 1);

        // R6: hit wins over clear in the same cycle
        m0 = 6'b000001;
        set_sec(6); after_tick();
        set_sec(5);
        do @(negedge clk); while (m_cnt != DIV - 1);
        clr = 1;
        @(negedge clk); clr = 0; #1;
        chk(flags[0] === 1'b1, "R6", "hit beats clear", int'(flags[0]), 1);
        pulse_clr();
        chk(flags[0] === 1'b0, "R6", "clear", int'(flags[0]), 0);

        // R7: disabled alarm sets flag only
        al0e = 0;
        arm_and_match(6, 5);
        chk(flags[0] === 1'b1, "R7", "flag while disabled", int'(flags[0]), 1);
        chk(pin === 1'b1, "R7", "pin while disabled", int'(pin), 1);
        pulse_clr();
        al0e = 1;

        // R3: clock select hides a pending latched alarm
        arm_and_match(6, 5);
        fo = 2'b11;
        do @(negedge clk); while (m_cnt != DIV / 2 + 1);
        #1;
        chk(pin === 1'b1, "R3", "1Hz high phase over alarm", int'(pin), 1);
        fo = 2'b10; repeat (40) @(negedge clk);
        fo = 2'b01; repeat (10) @(negedge clk);
        fo = 2'b00; #1;
        chk(pin === 1'b0, "R3", "alarm back on pin", int'(pin), 0);
        pulse_clr();

        // R8: pulsed mode, fixed width, re-fires per match
        im = 1;
        for (int k = 0; k < 2; k++) begin
            set_sec(6); after_tick();
            set_sec(5); after_tick();
            measure_low(n);
            chk(n == PULSE, "R8", "pulse width", n, PULSE);
        end
        pulse_clr();

        // R9: alarm 1 alone, pulsed then latched
        al0e = 0; al1e = 1; m1 = 6'b000010;
        cur = mk(3, 14, 2, 9, 44, 0); after_tick();
        cur = mk(3, 14, 2, 9, 45, 0); after_tick();
        measure_low(n);
        chk(n == PULSE, "R9", "alarm1 pulse width", n, PULSE);
        chk(flags === 2'b10, "R9", "alarm1 flag", int'(flags), 2);
        pulse_clr();
        im = 0;
        cur = mk(3, 14, 2, 9, 44, 0); after_tick();
        cur = mk(3, 14, 2, 9, 45, 0); after_tick(); #1;
        chk(pin === 1'b0, "R9", "alarm1 latched", int'(pin), 0);
        pulse_clr();

        // both alarms on the same tick, pulsed
        al0e = 1; im = 1;
        a0 = mk(3, 14, 2, 9, 45, 0); m0 = 6'b000011;
        cur = mk(3, 14, 2, 9, 44, 0); after_tick();
        cur = mk(3, 14, 2, 9, 45, 0); after_tick();
        measure_low(n);
        chk(n == PULSE, "R9", "joint pulse width", n, PULSE);
        chk(flags === 2'b11, "R9", "both flags", int'(flags), 3);

        repeat (20) @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule